// File: doc/BRIEF.md
# Sinc-Cubed Decimation Filter for a 1-Bit Modulator Stream

This block turns the single-bit output of a second-order delta-sigma modulator into 16-bit signed PCM words. It is a third-order cascaded integrator-comb filter. The order is three because it must be one higher than the modulator order. It decimates by 256, so a 5.12 MHz bit stream becomes a 20 kHz sample stream, which suits a 10 kHz voice band.

Only one clock reaches the block: the fast sample clock. The three integrators advance on every edge of that clock. A free-running counter inside the block raises a decimation enable once every 256 edges, and the three comb stages advance only on that enable. The comb result has its mid-scale offset removed and is cut down to 16 bits. Each finished word is presented together with a valid strobe that lasts one cycle. The first three decimated results after reset are dropped while the comb delay registers fill.

Top module: `cic_sinc3_decimator`

## Requirements
- R1: An input bit of 1 adds +1 to the first integrator and an input bit of 0 adds 0. All state is 25 bits wide and wraps modulo 2^25. The integrators advance on every clock edge, and the comb stages advance only on the decimation enable.
- R2: Each output word equals the raw sinc-cubed sum over the last three windows, minus 2^23, arithmetically shifted right by 8. For a steady periodic input whose period P divides 256 and which holds K ones per period, the word is (2^24*K/P - 2^23)/256. Example: P=4, K=1 gives -16384.
- R3: A steady all-ones input saturates to +32767. A steady all-zeros input gives -32768.
- R4: `pcm_valid` is high for exactly one cycle, every 256 clock edges. It rises after edges whose count since reset release is a multiple of 256.
- R5: The results of the first three decimation events after reset are suppressed. The first `pcm_valid` follows the 1024th clock edge after reset release.
- R6: A synchronous reset clears every integrator, comb register and counter. During reset and on the cycle after a reset edge, `pcm_valid` is 0 and `pcm_sample` is 0. After reset the start-up timing begins again.
- R7: `pcm_sample` holds its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock (nominal 5.12 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Serial modulator output bit |
| pcm_sample | output | 16 | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The hardest condition to reach from the ports is a steady-state result that a check can predict exactly. The filter keeps memory across three windows of 256 bits, and the 25-bit accumulators wrap. To get there, the stimulus drives periodic bit patterns whose period divides 256. Each such pattern gives a closed-form output, and the check is made on the fifth strobe after a pattern change, when no input from the previous pattern still falls inside the filter's span. The saturation edge is reached with an unbroken run of ones. The start-up suppression is reached by counting edges from a reset release, including a reset applied in the middle of a run.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int CIC_ORDER   = 3;
    localparam int DECIM_LOG2  = 8;
    localparam int PCM_W       = 16;
    localparam int ACC_W       = CIC_ORDER * DECIM_LOG2 + 1;

    typedef struct packed {
        logic strobe;   // decimation enable for this cycle
        logic armed;    // comb delay line already filled
    } dec_tick_t;
endpackage

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
    parameter int ORDER = cic_pkg::CIC_ORDER,
    parameter int W     = cic_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_in,
    output logic [W-1:0] integ_out
);
    logic [ORDER:0][W-1:0] src;

    assign src[0] = {{(W-1){1'b0}}, bit_in};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [W-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (rst) acc_q <= '0;
            else     acc_q <= acc_q + src[g];
        end
        assign src[g+1] = acc_q;
    end

    assign integ_out = src[ORDER];
endmodule

// File: rtl/cic_decim_timer.sv
module cic_decim_timer #(
    parameter int ORDER     = cic_pkg::CIC_ORDER,
    parameter int RATE_LOG2 = cic_pkg::DECIM_LOG2
) (
    input  logic                 clk,
    input  logic                 rst,
    output cic_pkg::dec_tick_t   tick
);
    localparam int FILL_W = $clog2(ORDER + 1);
    localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(ORDER);

    logic [RATE_LOG2-1:0] div_q;
    logic [FILL_W-1:0]    fill_q;
    logic                 at_wrap;

    assign at_wrap = &div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            fill_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
            if (at_wrap && fill_q != FILL_DONE)
                fill_q <= fill_q + 1'b1;
        end
    end

    assign tick.strobe = at_wrap;
    assign tick.armed  = (fill_q == FILL_DONE);
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int ORDER = cic_pkg::CIC_ORDER,
    parameter int W     = cic_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [W-1:0] comb_in,
    output logic [W-1:0] comb_out
);
    logic [ORDER:0][W-1:0] diff;

    assign diff[0] = comb_in;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [W-1:0] delay_q;
        always_ff @(posedge clk) begin
            if (rst)         delay_q <= '0;
            else if (enable) delay_q <= diff[g];
        end
        assign diff[g+1] = diff[g] - delay_q;
    end

    assign comb_out = diff[ORDER];
endmodule

// File: rtl/cic_output_stage.sv
module cic_output_stage #(
    parameter int W  = cic_pkg::ACC_W,
    parameter int OW = cic_pkg::PCM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  cic_pkg::dec_tick_t  tick,
    input  logic [W-1:0]        raw,
    output logic [OW-1:0]       pcm,
    output logic                pcm_stb
);
    localparam int           SHIFT  = W - 1 - OW;
    localparam logic [W-1:0] MID    = W'(1) << (W - 2);
    localparam logic [W-1:0] TOP_OK = (W'(1) << (OW - 1)) - W'(1);

    logic signed [W-1:0] centered;
    logic signed [W-1:0] scaled;
    logic [OW-1:0]       clamped;

    always_comb begin
        centered = $signed(raw - MID);
        scaled   = centered >>> SHIFT;
        if (scaled > $signed(TOP_OK)) clamped = TOP_OK[OW-1:0];
        else                          clamped = scaled[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcm     <= '0;
            pcm_stb <= 1'b0;
        end else begin
            pcm_stb <= tick.strobe && tick.armed;
            if (tick.strobe && tick.armed) pcm <= clamped;
        end
    end
endmodule

// File: rtl/cic_sinc3_decimator.sv
module cic_sinc3_decimator #(
    parameter int ORDER     = cic_pkg::CIC_ORDER,
    parameter int RATE_LOG2 = cic_pkg::DECIM_LOG2,
    parameter int OUT_W     = cic_pkg::PCM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] pcm_sample,
    output logic             pcm_valid
);
    localparam int ACC_BITS = ORDER * RATE_LOG2 + 1;

    logic [ACC_BITS-1:0] integ_sum;
    logic [ACC_BITS-1:0] comb_sum;
    cic_pkg::dec_tick_t  tick;

    cic_integrator_chain #(.ORDER(ORDER), .W(ACC_BITS)) u_integ (
        .clk(clk), .rst(rst), .bit_in(mod_bit), .integ_out(integ_sum)
    );

    cic_decim_timer #(.ORDER(ORDER), .RATE_LOG2(RATE_LOG2)) u_timer (
        .clk(clk), .rst(rst), .tick(tick)
    );

    cic_comb_chain #(.ORDER(ORDER), .W(ACC_BITS)) u_comb (
        .clk(clk), .rst(rst), .enable(tick.strobe),
        .comb_in(integ_sum), .comb_out(comb_sum)
    );

    cic_output_stage #(.W(ACC_BITS), .OW(OUT_W)) u_out (
        .clk(clk), .rst(rst), .tick(tick), .raw(comb_sum),
        .pcm(pcm_sample), .pcm_stb(pcm_valid)
    );
endmodule

// File: rtl/cic_sinc3_checker.sv
module cic_sinc3_checker #(
    parameter int RATE_LOG2 = cic_pkg::DECIM_LOG2,
    parameter int OUT_W     = cic_pkg::PCM_W
) (
    input logic             clk,
    input logic             rst,
    input logic [OUT_W-1:0] pcm_sample,
    input logic             pcm_valid
);
    logic [RATE_LOG2-1:0] phase_q;
    logic [2:0]           frames_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            frames_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
            if (&phase_q && frames_q != 3'd7) frames_q <= frames_q + 3'd1;
        end
    end

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    a_r4_on_boundary: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (phase_q == '0));

    a_r5_discard_fill: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (frames_q >= 3'd4));

    a_r6_reset_clear: assert property (@(posedge clk)
        rst |=> (!pcm_valid && pcm_sample == '0));

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> $stable(pcm_sample));
endmodule

bind cic_sinc3_decimator cic_sinc3_checker #(
    .RATE_LOG2(RATE_LOG2), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst(rst), .pcm_sample(pcm_sample), .pcm_valid(pcm_valid)
);

// File: tb/tb_cic_sinc3_decimator.sv
module tb_cic_sinc3_decimator;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    localparam int VPER [NVEC] = '{1, 1, 2, 4, 4, 8, 8, 16, 16, 256, 128};
    localparam int VONE [NVEC] = '{1, 0, 1, 1, 3, 1, 7, 1, 5, 1, 64};
    localparam int VEXP [NVEC] = '{32767, -32768, 0, -16384, 16384, -24576,
                                   24576, -28672, -12288, -32512, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_bit = 1'b0;
    logic [15:0] pcm_sample;
    logic        pcm_valid;

    int per = 1;
    int ones = 0;
    int ph = 0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    cic_sinc3_decimator dut (
        .clk(clk), .rst(rst), .mod_bit(mod_bit),
        .pcm_sample(pcm_sample), .pcm_valid(pcm_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        mod_bit <= (ph < ones);
        ph <= (ph + 1 >= per) ? 0 : ph + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!pcm_valid && gap < 5000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int gap;
        int held;
        bit moved;
        // R6: state during reset
        repeat (3) @(negedge clk);
        check("R6 reset valid", int'(pcm_valid), 0);
        check("R6 reset sample", int'($signed(pcm_sample)), 0);

        // R5: first strobe position with an all-ones stream
        per = 1; ones = 1;
        rst = 1'b0;
        wait_valid(gap);
        check("R5 first strobe edge", gap, 1024);
        // R4: one-cycle width and spacing
        @(negedge clk);
        check("R4 strobe width", int'(pcm_valid), 0);
        wait_valid(gap);
        check("R4 strobe spacing", gap + 1, 256);
        // R7: hold between strobes
        held = int'(pcm_sample);
        moved = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!pcm_valid && int'(pcm_sample) != held) moved = 1'b1;
        end
        check("R7 hold between strobes", int'(moved), 0);

        // R1 R2 R3: steady periodic patterns
        for (int v = 0; v < NVEC; v++) begin
            per = VPER[v]; ones = VONE[v];
            for (int k = 0; k < 5; k++) wait_valid(gap);
            if (v < 2)
                check("R3 saturation edge", int'($signed(pcm_sample)), VEXP[v]);
            else
                check("R1/R2 duty pattern", int'($signed(pcm_sample)), VEXP[v]);
        end

        // R6: mid-run reset then restart timing
        per = 4; ones = 1;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 mid-run valid", int'(pcm_valid), 0);
        check("R6 mid-run sample", int'($signed(pcm_sample)), 0);
        rst = 1'b0;
        wait_valid(gap);
        check("R5 restart strobe edge", gap, 1024);
        for (int k = 0; k < 4; k++) wait_valid(gap);
        check("R2 after restart", int'($signed(pcm_sample)), -16384);

        done = 1'b1;
        finish_run();
    end
endmodule